// File: doc/BRIEF.md
# Framed Serial PCM Port

This block moves 8-bit PCM words between a serial line and a parallel decoder/encoder interface. Its receive and transmit sides are independent. Each has its own bit-clock tick and its own 8 kHz frame sync. All state runs on one system clock. A side advances only in a cycle where its bit-clock tick input is high, so the ticks stand in for the two bit clocks. Bit rates from 128 kHz to 4.096 MHz give 16 to 512 ticks per frame.

The block works out the framing convention for each frame from how long the sync stays high:

- **Short framing.** A sync seen high at exactly one tick means data starts on the following tick.
- **Long framing.** A sync still high at the next tick means data starts on the tick where the sync rose.

On receive, the serial word is assembled most-significant bit first and presented in parallel. Each new rising receive sync also strobes the decoder to process the word completed in the previous frame. On transmit, the parallel word is captured at the rising transmit sync and shifted out most-significant bit first. A separate output-enable drives the tri-state control of the line pad.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `rx_word` is 0, `rx_decode` is 0, `tx_oe` is 0 and `tx_dout` is 0.
- R2: Frame syncs and receive data are sampled only in cycles where the side's tick is high. A rising sync is a sampled 1 that follows a sampled 0. Sync activity between ticks has no effect.
- R3: Short receive framing (sync sampled high at the rising tick, low at the next): the word is the `rx_din` values at the 8 ticks after the rising tick, first one in bit 7. Data at other ticks is ignored.
- R4: Long receive framing (sync still high at the tick after the rising tick, so any width of 2 or more): the word is the `rx_din` values at the rising tick and the 7 ticks after it, first one in bit 7.
- R5: In both framings, `rx_word` changes in the cycle after the eighth tick that follows the rising tick. It then holds until the next completed word.
- R6: `rx_decode` is a one-cycle pulse in the cycle after a tick that samples a rising receive sync. It is raised only if a word has been completed since the previous pulse, so the first frame after reset gives no pulse.
- R7: Long transmit framing: `tx_oe` is high in the interval after the rising tick and the 7 intervals after that. `tx_dout` carries `tx_word` bits 7 down to 0 in those intervals.
- R8: Short transmit framing: `tx_oe` is low once the sync has fallen after the rising tick. It is high for the 8 intervals that follow the next tick, carrying bits 7 down to 0.
- R9: `tx_dout` is 0 whenever `tx_oe` is 0, so the line is high-impedance outside the 8-bit window.
- R10: `tx_word` is captured at the tick that samples a rising transmit sync. Changes to it during the frame do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bclk_tick | input | 1 | One-cycle pulse per receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_din | input | 1 | Receive serial data |
| rx_word | output | 8 | Last completed received word |
| rx_decode | output | 1 | Strobe: `rx_word` is ready for decoding |
| tx_bclk_tick | input | 1 | One-cycle pulse per transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_word | input | 8 | Word to send in the next frame |
| tx_dout | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Pad drive enable; low means high-impedance |

## Verification
The assertions assume the following about the inputs:

- Each bit-clock tick is a single-cycle pulse.
- Sync and data inputs change only between ticks.
- A new frame does not start until the previous word has finished.

The stimulus follows these assumptions. It raises a tick every fourth clock and changes sync and data one clock after each tick. Frames are 16 ticks long, with sync widths of 1, 2 and 8.

On the transmit side, the enable in the first interval follows the live sync input. The bench therefore samples only after the sync has settled for that interval. It also pulses both syncs between ticks to show that those pulses are ignored.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    typedef enum logic {
        FRAME_SHORT = 1'b0,
        FRAME_LONG  = 1'b1
    } frame_mode_e;

    function automatic frame_mode_e mode_of(input logic sync_level);
        return sync_level ? FRAME_LONG : FRAME_SHORT;
    endfunction
endpackage

// File: rtl/pcm_fsync_sampler.sv
module pcm_fsync_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fsync,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (tick) smp_d.prev = fsync;
        rise = tick && fsync && !smp_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    // R2
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> tick && fsync);
endmodule

// File: rtl/pcm_rx_side.sv
module pcm_rx_side
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fsync,
    input  logic              rise,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              decode
);
    localparam int SLOT_W = $clog2(WORD_W + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORD_W - 1);

    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] slot;
        frame_mode_e       mode;
        logic [WORD_W:0]   sh;
        logic [WORD_W-1:0] word;
        logic              pending;
        logic              decode;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [WORD_W:0] sh_next;
    frame_mode_e     mode_now;

    always_comb begin
        rx_d        = rx_q;
        rx_d.decode = 1'b0;
        sh_next     = {rx_q.sh[WORD_W-1:0], din};
        mode_now    = (rx_q.slot == '0) ? mode_of(fsync) : rx_q.mode;
        if (tick) begin
            if (rise) begin
                rx_d.active  = 1'b1;
                rx_d.slot    = '0;
                rx_d.sh      = sh_next;
                rx_d.decode  = rx_q.pending;
                rx_d.pending = 1'b0;
            end else if (rx_q.active) begin
                rx_d.sh   = sh_next;
                rx_d.mode = mode_now;
                if (rx_q.slot == LAST_SLOT) begin
                    rx_d.active  = 1'b0;
                    rx_d.pending = 1'b1;
                    rx_d.word    = (mode_now == FRAME_LONG) ? sh_next[WORD_W:1]
                                                            : sh_next[WORD_W-1:0];
                end else begin
                    rx_d.slot = rx_q.slot + 1'b1;
                end
            end
        end
        word   = rx_q.word;
        decode = rx_q.decode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    // R6
    decode_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decode |-> $past(tick && fsync));
    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(word));
    // R3
    rx_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.active |-> rx_q.slot <= LAST_SLOT);
endmodule

// File: rtl/pcm_tx_side.sv
module pcm_tx_side
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fsync,
    input  logic              rise,
    input  logic [WORD_W-1:0] word,
    output logic              dout,
    output logic              oe
);
    localparam int SLOT_W = $clog2(WORD_W + 1);
    localparam logic [SLOT_W-1:0] END_LONG  = SLOT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] END_SHORT = SLOT_W'(WORD_W);

    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] slot;
        frame_mode_e       mode;
        logic [WORD_W-1:0] sh;
    } tx_t;

    tx_t  tx_d, tx_q;
    logic last_slot;

    always_comb begin
        tx_d      = tx_q;
        last_slot = (tx_q.mode == FRAME_LONG) ? (tx_q.slot == END_LONG)
                                              : (tx_q.slot == END_SHORT);
        if (tick) begin
            if (rise) begin
                tx_d.active = 1'b1;
                tx_d.slot   = '0;
                tx_d.sh     = word;
            end else if (tx_q.active) begin
                if (tx_q.slot == '0) begin
                    tx_d.mode = mode_of(fsync);
                    tx_d.slot = SLOT_W'(1);
                    if (fsync) tx_d.sh = tx_q.sh << 1;
                end else if (last_slot) begin
                    tx_d.active = 1'b0;
                end else begin
                    tx_d.sh   = tx_q.sh << 1;
                    tx_d.slot = tx_q.slot + 1'b1;
                end
            end
        end
        oe   = tx_q.active && ((tx_q.slot == '0) ? fsync : 1'b1);
        dout = oe && tx_q.sh[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    // R9
    oe_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> tx_q.active);
    // R10
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tx_q.sh));
    // R7
    tx_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.active |-> tx_q.slot <= END_SHORT);
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bclk_tick,
    input  logic              rx_fsync,
    input  logic              rx_din,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_decode,
    input  logic              tx_bclk_tick,
    input  logic              tx_fsync,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_dout,
    output logic              tx_oe
);
    logic rx_rise, tx_rise;

    pcm_fsync_sampler u_rx_sync (
        .clk(clk), .rst_n(rst_n), .tick(rx_bclk_tick), .fsync(rx_fsync), .rise(rx_rise)
    );

    pcm_fsync_sampler u_tx_sync (
        .clk(clk), .rst_n(rst_n), .tick(tx_bclk_tick), .fsync(tx_fsync), .rise(tx_rise)
    );

    pcm_rx_side #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(rx_bclk_tick), .fsync(rx_fsync),
        .rise(rx_rise), .din(rx_din), .word(rx_word), .decode(rx_decode)
    );

    pcm_tx_side #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tx_bclk_tick), .fsync(tx_fsync),
        .rise(tx_rise), .word(tx_word), .dout(tx_dout), .oe(tx_oe)
    );

    // R9
    dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_dout);
endmodule

// File: tb/pcm_serial_port_test.sv
module pcm_serial_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bclk_tick = 1'b0, rx_fsync = 1'b0, rx_din = 1'b0;
    logic       tx_bclk_tick = 1'b0, tx_fsync = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic [7:0] rx_word;
    logic       rx_decode, tx_dout, tx_oe;

    pcm_serial_port uut (
        .clk(clk), .rst_n(rst_n),
        .rx_bclk_tick(rx_bclk_tick), .rx_fsync(rx_fsync), .rx_din(rx_din),
        .rx_word(rx_word), .rx_decode(rx_decode),
        .tx_bclk_tick(tx_bclk_tick), .tx_fsync(tx_fsync), .tx_word(tx_word),
        .tx_dout(tx_dout), .tx_oe(tx_oe)
    );

    always #10 clk = ~clk;

    int   checks = 0;
    int   errors = 0;
    bit   checking = 1'b0;
    bit   pending = 1'b0;
    logic [7:0] exp_word = 8'h00;
    logic exp_dec = 1'b0, exp_oe = 1'b0, exp_dout = 1'b0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model compared on every clock
    always @(negedge clk) begin
        if (checking) begin
            #1;
            check("R3/R4/R5 rx_word", 32'(rx_word), 32'(exp_word));
            check("R6 rx_decode", 32'(rx_decode), 32'(exp_dec));
            check("R7/R8 tx_oe", 32'(tx_oe), 32'(exp_oe));
            check("R9/R10 tx_dout", 32'(tx_dout), 32'(exp_dout));
        end
    end

    // drive the inputs that the tick with index kk will sample
    task automatic drive(int kk, int rw, logic [7:0] rb, int tw);
        rx_fsync = (kk < rw);
        tx_fsync = (kk < tw);
        if (rw > 1) rx_din = (kk < 8) ? rb[7-kk] : 1'($urandom);
        else        rx_din = (kk >= 1 && kk <= 8) ? rb[8-kk] : 1'($urandom);
    endtask

    task automatic frame(int rw, logic [7:0] rb, int tw, logic [7:0] tb);
        tx_word = tb;
        drive(0, rw, rb, tw);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            rx_bclk_tick = 1'b1;
            tx_bclk_tick = 1'b1;
            @(negedge clk);
            rx_bclk_tick = 1'b0;
            tx_bclk_tick = 1'b0;
            exp_dec = (k == 0) && pending;          // R6
            if (k == 0) pending = 1'b0;
            if (k == 8) begin exp_word = rb; pending = 1'b1; end  // R5
            if (tw > 1) begin                       // R7
                exp_oe   = (k <= 7);
                exp_dout = (k <= 7) ? tb[7-k] : 1'b0;
            end else begin                          // R8
                exp_oe   = (k >= 1 && k <= 8);
                exp_dout = (k >= 1 && k <= 8) ? tb[8-k] : 1'b0;
            end
            if (k == 0) tx_word = 8'($urandom);     // R10
            drive(k + 1, rw, rb, tw);
            @(negedge clk);
            exp_dec = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 rx_word", 32'(rx_word), 32'h0);
        check("R1 rx_decode", 32'(rx_decode), 32'h0);
        check("R1 tx_oe", 32'(tx_oe), 32'h0);
        check("R1 tx_dout", 32'(tx_dout), 32'h0);
        rst_n = 1'b1;
        checking = 1'b1;
        @(negedge clk);
        frame(1, 8'hA5, 1, 8'h3C);   // R3 R8
        frame(8, 8'h5A, 8, 8'hC3);   // R4 R7
        frame(1, 8'h00, 8, 8'hFF);
        frame(8, 8'hFF, 1, 8'h00);
        frame(2, 8'h80, 2, 8'h01);   // width 2 counts as long
        frame(1, 8'h01, 1, 8'h80);
        // R2: sync pulses between ticks must be ignored
        @(negedge clk);
        rx_fsync = 1'b1;
        tx_fsync = 1'b1;
        @(negedge clk);
        rx_fsync = 1'b0;
        tx_fsync = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++)
            frame((i % 2) ? 8 : 1, 8'($urandom), (i < 2) ? 1 : 8, 8'($urandom));
        frame(8, 8'h69, 8, 8'h96);
        checking = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule